// File: doc/BRIEF.md
# Link Rate and Lane Count Selector

This block chooses a serial display link configuration for a requested video mode. It takes the pixel clock in kHz, the highest link rate and lane count the sink advertises, and the monitor's bits per colour. It then searches for the cheapest configuration that carries the stream. Lower link rates are preferred over fewer lanes: each rate is tried from slowest to fastest, and at each rate the lane count doubles from one. The first combination whose payload capacity covers the pixel clock wins.

The search is a small sequential engine. A one-cycle start pulse captures all inputs. The engine then evaluates one candidate per clock and reports on a single-cycle done pulse. The result is a lane count and a link rate, or a failure flag with both zeroed. A mode-valid verdict comes with the result and accounts for whether the sink supports the higher-bandwidth protocol level. A bridge mode pins the search to the middle rate. Reading the sink's capabilities and programming the link are handled elsewhere.

Top module: `link_rate_selector`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy`, `done`, `fail`, `mode_ok`, `lane_cnt` and `rate_khz` are all zero.
- R2: Bits per pixel is 24 when `bpc` is 0, and 3 × `bpc` otherwise.
- R3: A candidate of L lanes at rate R fits when floor(L × R × 8 / bpp) ≥ `pix_khz`, using integer division.
- R4: Candidate rates are 162000, 270000 and 540000 kHz, tried in ascending order. At each rate the lane counts 1, 2 and 4 are tried in that order. The first fitting candidate is returned, so `lane_cnt` is always a power of two.
- R5: Rates above `sink_rate_khz` and lane counts above `sink_lanes` are never chosen.
- R6: When `bridge_mode` is 1, only the 270000 kHz rate is considered.
- R7: When no candidate fits, `fail` is 1, `lane_cnt` and `rate_khz` are 0, and `mode_ok` is 0.
- R8: `mode_ok` is 1 only when a candidate fits and both of these hold: `pix_khz` ≤ 340000 or `hi_rate_cap` is 1; the chosen rate is not 540000 or `hi_rate_cap` is 1.
- R9: A `start` seen while `busy` is 0 begins a search, and `busy` is 1 on the next cycle. A `start` while busy is ignored, including its input values. Each accepted start yields exactly one single-cycle `done`, and `busy` is 0 in that cycle.
- R10: `lane_cnt`, `rate_khz`, `fail` and `mode_ok` change only in the cycle `done` is 1. They hold between searches whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search with the current inputs |
| pix_khz | input | PIX_W | Requested pixel clock in kHz |
| sink_rate_khz | input | 20 | Highest link rate the sink accepts, kHz |
| sink_lanes | input | LANE_W | Highest lane count the sink accepts |
| bpc | input | BPC_W | Monitor bits per colour (0 means default) |
| bridge_mode | input | 1 | Restrict the search to the 270000 kHz rate |
| hi_rate_cap | input | 1 | Sink supports the higher-bandwidth protocol level |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a result is ready |
| fail | output | 1 | No configuration fits |
| lane_cnt | output | LANE_W | Chosen lane count |
| rate_khz | output | 20 | Chosen link rate in kHz |
| mode_ok | output | 1 | Mode is valid for this sink |

## Verification
The bench builds the block with its default widths: a 20-bit pixel clock, a 3-bit lane count and a 5-bit colour depth. These widths give lane counts 1, 2 and 4 and the full 162000/270000/540000 ladder. They also allow pixel clocks far above what any configuration carries, so both the success and failure paths are reachable. Directed cases sit on exact integer-division boundaries (for example a bpp of 21, where the capacity is truncated) and on limited sinks. They also cover bridge mode and both branches of the mode-valid rule. Random cases sweep sink limits, colour depths and pixel clocks against a bench model.

// File: rtl/lrsel_pkg.sv
package lrsel_pkg;

    localparam int RATE_W    = 20;
    localparam int NUM_RATES = 3;
    localparam int RIDX_W    = 2;

    localparam logic [RATE_W-1:0] BRIDGE_RATE = 20'd270000;
    localparam logic [RATE_W-1:0] TOP_RATE    = 20'd540000;
    localparam int                MODE_PIX_LIMIT = 340000;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } state_t;

    // request fields held for the whole search
    typedef struct packed {
        logic [RATE_W-1:0] max_rate;
        logic              bridge;
        logic              cap;
    } req_t;

    // candidate rate ladder, ascending
    function automatic logic [RATE_W-1:0] rate_at(input logic [RIDX_W-1:0] idx);
        logic [RATE_W-1:0] r;
        case (idx)
            2'd0:    r = 20'd162000;
            2'd1:    r = 20'd270000;
            2'd2:    r = 20'd540000;
            default: r = '0;
        endcase
        return r;
    endfunction

    // bits per pixel from bits per colour
    function automatic logic [9:0] bpp_of(input logic [7:0] bpc_in);
        logic [9:0] b;
        if (bpc_in == 8'd0) b = 10'd24;
        else                b = {2'b00, bpc_in} * 10'd3;
        return b;
    endfunction

endpackage

// File: rtl/lrsel_walker.sv
module lrsel_walker
    import lrsel_pkg::*;
#(
    parameter int LANE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step_lane,
    input  logic              step_rate,
    output logic [RATE_W-1:0] cur_rate,
    output logic [LANE_W-1:0] cur_lanes,
    output logic              last_rate,
    output logic              last_lane
);
    localparam int LANE_STEPS = LANE_W;
    localparam int LL_W = (LANE_STEPS > 1) ? $clog2(LANE_STEPS) : 1;

    logic [RIDX_W-1:0] ridx;
    logic [LL_W-1:0]   lane_log;

    always_ff @(posedge clk) begin
        if (rst) begin
            ridx     <= '0;
            lane_log <= '0;
        end else if (load) begin
            ridx     <= '0;
            lane_log <= '0;
        end else if (step_rate) begin
            ridx     <= ridx + RIDX_W'(1);
            lane_log <= '0;
        end else if (step_lane) begin
            lane_log <= lane_log + LL_W'(1);
        end
    end

    always_comb begin
        cur_rate  = rate_at(ridx);
        cur_lanes = LANE_W'(1) << lane_log;
        last_rate = (ridx == RIDX_W'(NUM_RATES - 1));
        last_lane = (lane_log == LL_W'(LANE_STEPS - 1));
    end

endmodule

// File: rtl/lrsel_fit.sv
module lrsel_fit
    import lrsel_pkg::*;
#(
    parameter int LANE_W = 3,
    parameter int PIX_W  = 20
) (
    input  logic [LANE_W-1:0] lanes,
    input  logic [RATE_W-1:0] rate,
    input  logic [PIX_W-1:0]  pix,
    input  logic [9:0]        bpp,
    output logic              fits
);
    // floor(L*R*8/bpp) >= pix  is exactly  L*R*8 >= pix*bpp
    localparam int CAP_W  = LANE_W + RATE_W + 3;
    localparam int DEM_W  = PIX_W + 10;
    localparam int PROD_W = ((CAP_W > DEM_W) ? CAP_W : DEM_W) + 1;

    logic [PROD_W-1:0] capacity;
    logic [PROD_W-1:0] demand;

    always_comb begin
        capacity = (PROD_W'(lanes) * PROD_W'(rate)) << 3;
        demand   = PROD_W'(pix) * PROD_W'(bpp);
        fits     = (capacity >= demand);
    end

endmodule

// File: rtl/lrsel_verdict.sv
module lrsel_verdict
    import lrsel_pkg::*;
#(
    parameter int PIX_W = 20
) (
    input  logic              found,
    input  logic [PIX_W-1:0]  pix,
    input  logic [RATE_W-1:0] rate,
    input  logic              cap,
    output logic              ok
);
    logic pix_too_high;
    logic rate_too_high;

    always_comb begin
        pix_too_high  = ({32'd0, pix} > 64'(MODE_PIX_LIMIT)) && !cap;
        rate_too_high = (rate == TOP_RATE) && !cap;
        ok            = found && !pix_too_high && !rate_too_high;
    end

endmodule

// File: rtl/link_rate_selector.sv
module link_rate_selector
    import lrsel_pkg::*;
#(
    parameter int PIX_W  = 20,
    parameter int LANE_W = 3,
    parameter int BPC_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PIX_W-1:0]  pix_khz,
    input  logic [19:0]       sink_rate_khz,
    input  logic [LANE_W-1:0] sink_lanes,
    input  logic [BPC_W-1:0]  bpc,
    input  logic              bridge_mode,
    input  logic              hi_rate_cap,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [LANE_W-1:0] lane_cnt,
    output logic [19:0]       rate_khz,
    output logic              mode_ok
);
    state_t            state;
    req_t              req_q;
    logic [PIX_W-1:0]  pix_q;
    logic [LANE_W-1:0] max_lanes_q;
    logic [9:0]        bpp_q;
    logic              bridge_q;
    logic              cap_q;
    logic [RATE_W-1:0] max_rate_q;

    logic              done_q, fail_q, ok_q;
    logic [LANE_W-1:0] lanes_q;
    logic [RATE_W-1:0] rate_q;

    logic [RATE_W-1:0] cur_rate;
    logic [LANE_W-1:0] cur_lanes;
    logic              last_rate, last_lane;
    logic              fits, verdict_ok;
    logic              rate_ok, lane_ok, cand_ok, cand_fit;
    logic              load, step_lane, step_rate, give_up, searching;

    assign bridge_q   = req_q.bridge;
    assign cap_q      = req_q.cap;
    assign max_rate_q = req_q.max_rate;

    always_comb begin
        searching = (state == ST_SEARCH);
        rate_ok   = (cur_rate <= max_rate_q) && (!bridge_q || cur_rate == BRIDGE_RATE);
        lane_ok   = (cur_lanes <= max_lanes_q);
        cand_ok   = rate_ok && lane_ok;
        cand_fit  = searching && cand_ok && fits;
        load      = (state == ST_IDLE) && start;
        step_lane = searching && cand_ok && !fits && !last_lane;
        step_rate = searching && !cand_fit && !step_lane && !last_rate;
        give_up   = searching && !cand_fit && !step_lane && last_rate;
    end

    lrsel_walker #(.LANE_W(LANE_W)) u_walker (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step_lane (step_lane),
        .step_rate (step_rate),
        .cur_rate  (cur_rate),
        .cur_lanes (cur_lanes),
        .last_rate (last_rate),
        .last_lane (last_lane)
    );

    lrsel_fit #(.LANE_W(LANE_W), .PIX_W(PIX_W)) u_fit (
        .lanes (cur_lanes),
        .rate  (cur_rate),
        .pix   (pix_q),
        .bpp   (bpp_q),
        .fits  (fits)
    );

    lrsel_verdict #(.PIX_W(PIX_W)) u_verdict (
        .found (cand_fit),
        .pix   (pix_q),
        .rate  (cur_rate),
        .cap   (cap_q),
        .ok    (verdict_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            req_q       <= '0;
            pix_q       <= '0;
            max_lanes_q <= '0;
            bpp_q       <= '0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
            ok_q        <= 1'b0;
            lanes_q     <= '0;
            rate_q      <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q.max_rate <= sink_rate_khz;
                        req_q.bridge   <= bridge_mode;
                        req_q.cap      <= hi_rate_cap;
                        pix_q          <= pix_khz;
                        max_lanes_q    <= sink_lanes;
                        bpp_q          <= bpp_of(8'(bpc));
                        state          <= ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (cand_fit) begin
                        lanes_q <= cur_lanes;
                        rate_q  <= cur_rate;
                        fail_q  <= 1'b0;
                        ok_q    <= verdict_ok;
                        done_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (give_up) begin
                        lanes_q <= '0;
                        rate_q  <= '0;
                        fail_q  <= 1'b1;
                        ok_q    <= 1'b0;
                        done_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy     = searching;
    assign done     = done_q;
    assign fail     = fail_q;
    assign lane_cnt = lanes_q;
    assign rate_khz = rate_q;
    assign mode_ok  = ok_q;

endmodule

// File: rtl/link_rate_selector_chk.sv
module link_rate_selector_chk #(
    parameter int PIX_W  = 20,
    parameter int LANE_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              mode_ok,
    input logic [LANE_W-1:0] lane_cnt,
    input logic [19:0]       rate_khz,
    input logic [19:0]       max_rate_q,
    input logic [LANE_W-1:0] max_lanes_q,
    input logic [PIX_W-1:0]  pix_q,
    input logic              bridge_q,
    input logic              cap_q
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!busy && !done && !fail && !mode_ok && lane_cnt == '0 && rate_khz == '0));

    // R9
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_start_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R7
    a_r7_fail_zero: assert property (@(posedge clk) disable iff (rst)
        fail |-> (lane_cnt == '0 && rate_khz == '0 && !mode_ok));

    // R4
    a_r4_lane_pow2: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> ($countones(lane_cnt) == 1));

    // R5
    a_r5_within_sink: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> (rate_khz <= max_rate_q && lane_cnt <= max_lanes_q));

    // R6
    a_r6_bridge_rate: assert property (@(posedge clk) disable iff (rst)
        (done && !fail && bridge_q) |-> (rate_khz == 20'd270000));

    // R8
    a_r8_mode_rule: assert property (@(posedge clk) disable iff (rst)
        (done && mode_ok) |-> (!fail && (cap_q ||
            (rate_khz != 20'd540000 && {12'd0, pix_q} <= 32'd340000))));

    // R10
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(lane_cnt) && $stable(rate_khz) && $stable(fail) && $stable(mode_ok)));

endmodule

bind link_rate_selector link_rate_selector_chk #(.PIX_W(PIX_W), .LANE_W(LANE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .mode_ok     (mode_ok),
    .lane_cnt    (lane_cnt),
    .rate_khz    (rate_khz),
    .max_rate_q  (max_rate_q),
    .max_lanes_q (max_lanes_q),
    .pix_q       (pix_q),
    .bridge_q    (bridge_q),
    .cap_q       (cap_q)
);

// File: tb/link_rate_selector_bench.sv
module link_rate_selector_bench;
    localparam int PIX_W  = 20;
    localparam int LANE_W = 3;
    localparam int BPC_W  = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [PIX_W-1:0]  pix_khz = '0;
    logic [19:0]       sink_rate_khz = '0;
    logic [LANE_W-1:0] sink_lanes = '0;
    logic [BPC_W-1:0]  bpc = '0;
    logic              bridge_mode = 1'b0;
    logic              hi_rate_cap = 1'b0;
    logic              busy, done, fail, mode_ok;
    logic [LANE_W-1:0] lane_cnt;
    logic [19:0]       rate_khz;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    link_rate_selector #(.PIX_W(PIX_W), .LANE_W(LANE_W), .BPC_W(BPC_W)) u_link_rate_selector (
        .clk (clk), .rst (rst), .start (start), .pix_khz (pix_khz),
        .sink_rate_khz (sink_rate_khz), .sink_lanes (sink_lanes), .bpc (bpc),
        .bridge_mode (bridge_mode), .hi_rate_cap (hi_rate_cap),
        .busy (busy), .done (done), .fail (fail), .lane_cnt (lane_cnt),
        .rate_khz (rate_khz), .mode_ok (mode_ok)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model built from the requirements
    task automatic model(input int pix, input int maxr, input int maxl, input int bpcv,
                         input bit br, input bit cap,
                         output int e_l, output int e_r, output bit e_f, output bit e_ok);
        int rates [3] = '{162000, 270000, 540000};
        int bppv;
        bit found;
        bppv = (bpcv == 0) ? 24 : 3 * bpcv;
        found = 0; e_l = 0; e_r = 0;
        for (int i = 0; i < 3 && !found; i++) begin
            if (rates[i] > maxr) continue;
            if (br && rates[i] != 270000) continue;
            for (int l = 1; l <= 4 && !found; l = l * 2) begin
                if (l > maxl) break;
                if ((longint'(l) * rates[i] * 8) / bppv >= pix) begin
                    found = 1; e_l = l; e_r = rates[i];
                end
            end
        end
        e_f = !found;
        e_ok = found && !(pix > 340000 && !cap) && !(e_r == 540000 && !cap);
    endtask

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 60; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run(input int pix, input int maxr, input int maxl, input int bpcv,
                       input bit br, input bit cap, input string tag);
        int e_l, e_r; bit e_f, e_ok, got;
        model(pix, maxr, maxl, bpcv, br, cap, e_l, e_r, e_f, e_ok);
        @(negedge clk);
        pix_khz = PIX_W'(pix); sink_rate_khz = 20'(maxr); sink_lanes = LANE_W'(maxl);
        bpc = BPC_W'(bpcv); bridge_mode = br; hi_rate_cap = cap; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(got);
        chk(got, {tag, " R9 done seen"}, got, 1);
        chk(lane_cnt == LANE_W'(e_l), {tag, " lanes"}, lane_cnt, e_l);
        chk(rate_khz == 20'(e_r), {tag, " rate"}, rate_khz, e_r);
        chk(fail == e_f, {tag, " R7 fail"}, fail, e_f);
        chk(mode_ok == e_ok, {tag, " R8 mode_ok"}, mode_ok, e_ok);
        @(negedge clk);
        chk(!done, {tag, " R9 single pulse"}, done, 0);
    endtask

    initial begin
        int dn;
        bit got;
        int rl [3] = '{162000, 270000, 540000};
        int bl [6] = '{0, 6, 8, 10, 12, 16};
        int seed_dummy;
        seed_dummy = $urandom(32'h1a2b3c);

        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !mode_ok && lane_cnt == 0 && rate_khz == 0,
            "R1 reset state", {busy, done, fail, mode_ok}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(lane_cnt == 0 && rate_khz == 0 && !done, "R1 after release", rate_khz, 0);

        // R2: bpc 0 gives 24 bpp -> 1 lane at 162000 carries 54000
        run(50000, 540000, 4, 0, 0, 0, "R2 default bpp");
        run(54001, 540000, 4, 0, 0, 0, "R2 default bpp edge");
        // R4: ascending search
        run(148500, 540000, 4, 8, 0, 0, "R4 four lanes low rate");
        // R3: bpp 21 -> floor(1296000/21)=61714
        run(61714, 540000, 4, 7, 0, 0, "R3 floor exact");
        run(61715, 540000, 4, 7, 0, 0, "R3 floor plus one");
        // R5: lane limit moves to next rate; rate limit forces failure
        run(148500, 540000, 2, 8, 0, 0, "R5 lane limit");
        run(148500, 162000, 2, 8, 0, 0, "R5 R7 rate limit fail");
        run(148500, 540000, 3, 8, 0, 0, "R5 three lane sink");
        run(1000, 540000, 0, 8, 0, 1, "R5 R7 zero lanes");
        // R6: bridge pins 270000
        run(50000, 540000, 4, 8, 1, 0, "R6 bridge low clock");
        run(400000, 540000, 4, 8, 1, 1, "R6 R7 bridge no fit");
        run(50000, 162000, 4, 8, 1, 0, "R6 bridge sink too slow");
        // R8: mode validity
        run(350000, 540000, 4, 8, 0, 0, "R8 pix above limit no cap");
        run(350000, 540000, 4, 8, 0, 1, "R8 pix above limit cap");
        run(150000, 540000, 1, 8, 0, 0, "R8 top rate no cap");
        run(150000, 540000, 1, 8, 0, 1, "R8 top rate cap");
        run(1000000, 540000, 4, 16, 0, 1, "R7 far too high");

        // R9: start held while busy with new inputs is ignored
        @(negedge clk);
        pix_khz = 50000; sink_rate_khz = 540000; sink_lanes = 4; bpc = 0;
        bridge_mode = 0; hi_rate_cap = 0; start = 1'b1;
        @(negedge clk);
        pix_khz = 900000;
        @(negedge clk);
        start = 1'b0;
        wait_done(got);
        chk(got && !fail && lane_cnt == 1 && rate_khz == 162000, "R9 busy start ignored",
            rate_khz, 162000);
        dn = 0;
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (done) dn++;
            @(negedge clk);
        end
        chk(dn == 0, "R9 no extra done", dn, 0);

        // R10: outputs hold while inputs move without start
        for (int i = 0; i < 8; i++) begin
            pix_khz = PIX_W'($urandom % 900000); sink_lanes = LANE_W'($urandom % 5);
            bridge_mode = 1'($urandom); hi_rate_cap = 1'($urandom);
            @(negedge clk);
        end
        chk(!done && !fail && lane_cnt == 1 && rate_khz == 162000, "R10 hold", rate_khz, 162000);

        // random sweep, R4
        for (int n = 0; n < 300; n++) begin
            run(1 + ($urandom % 600000), rl[$urandom % 3], $urandom % 5, bl[$urandom % 6],
                ($urandom % 8) == 0, 1'($urandom), "R4 random");
        end

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule